// File: doc/BRIEF.md
# Four-Channel Power-of-Two Clock Enable Scaler

This block gives each of four peripheral instances its own module clock, derived from one shared system clock. Software places a 4-bit scale code into a per-channel setting through a simple write port. Each channel then either stays off or produces a single-cycle enable strobe. The strobe fires on every system clock cycle or once every 2, 4, 8, 16, 32, 64, 128 or 256 cycles. The peripheral logic stays on the system clock and advances only on cycles where its strobe is high, so there is a single clock domain.

Each channel reports whether it is running. Each channel also has a sticky flag that records a write of an illegal code. Every channel has an access-request input. A request to a running channel is passed through as a grant. A request to a channel that is not running is blocked and reported as an access error in the same cycle.

Top module: `clk_scaler_bank`

## Requirements
- R1: After a synchronous active-low reset, every channel holds code 0: `clk_en`, `ch_active` and `code_rsvd` are all zero.
- R2: A channel holding code 0 produces no enable strobe, and its `ch_active` is low.
- R3: Code 1 makes the channel's `clk_en` high in every cycle, starting with the first cycle after the write edge.
- R4: Code c in 2..9 gives strobes that are one cycle wide and spaced exactly 2^(c-1) cycles apart.
- R5: After a write of a legal nonzero code with divide D, the first strobe appears in the D-th cycle after the write edge. The channel's count restarts on every write, including a rewrite in the middle of a period.
- R6: Codes 10..15 behave as off: no strobes, `ch_active` low, and requests are refused. Such a write sets that channel's `code_rsvd`, which stays set until reset.
- R7: A write addressed to one channel (`wr_ch` = channel index) leaves the code, count and flags of every other channel unchanged.
- R8: In the same cycle, `acc_grant[i]` equals `acc_req[i]` when channel i is active, and `acc_err[i]` equals `acc_req[i]` when it is not.
- R9: `ch_active[i]` is high exactly when channel i holds a code in 1..9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Setting write strobe |
| wr_ch | input | 2 | Channel index addressed by the write |
| wr_code | input | 4 | Scale code being written |
| acc_req | input | 4 | Per-channel peripheral access request |
| clk_en | output | 4 | Per-channel module clock enable strobe |
| ch_active | output | 4 | Channel holds a legal running code |
| code_rsvd | output | 4 | Sticky: an illegal code was written to the channel |
| acc_grant | output | 4 | Request forwarded to a running channel |
| acc_err | output | 4 | Request refused because the channel is off |

## Verification
The bench targets the phase of the first strobe after a write. A counter that is not cleared on a write, or that is off by one, would produce a short first period or a doubled strobe. The bench rewrites a divided channel in the middle of its period and checks that the neighbouring channels keep their own cadence. A shared or wrongly decoded write would make a neighbour restart or stall. It writes both boundary reserved codes and then a return to zero. A design that decoded code 10 as divide-by-512, or that cleared the flag on a later write, would strobe or drop the flag. Access requests are applied across off, reserved and running states, so a gate that read the raw code instead of its legality would grant on a reserved channel.

// File: rtl/clk_scaler_pkg.sv
// Package: shared constants and helpers for the clock enable scaler.
// Assumes the scale code is log-encoded: 0 off, n gives divide 2^(n-1).
package clk_scaler_pkg;

    // Code that turns a channel off; also the reset value.
    localparam int unsigned CODE_OFF = 0;

    // Decoded view of a stored scale code.
    typedef struct packed {
        logic running;   // legal nonzero code
        logic illegal;   // code above the legal range
    } scale_mode_t;

endpackage

// File: rtl/scale_decode.sv
// scale_decode: turns a stored scale code into a run flag, an illegal-code
// flag and the terminal count of the divide counter.
// Assumes CNT_W = MAX_CODE-1 so the largest divide fits the counter.
module scale_decode
    import clk_scaler_pkg::*;
#(
    parameter int unsigned CODE_W   = 4,
    parameter int unsigned MAX_CODE = 9,
    parameter int unsigned CNT_W    = MAX_CODE - 1
) (
    input  logic [CODE_W-1:0] code,
    output scale_mode_t       mode,
    output logic [CNT_W-1:0]  term_cnt
);

    logic [CNT_W:0] pow2;
    logic [CNT_W:0] pow2_m1;

    // Classify the code as off, running or illegal.
    always_comb begin
        mode.illegal = (code > CODE_W'(MAX_CODE));
        mode.running = (code != CODE_W'(CODE_OFF)) && !mode.illegal;
    end

    // Terminal count is 2^(code-1) - 1 for a running code, else zero.
    always_comb begin
        pow2    = '0;
        pow2_m1 = '0;
        if (mode.running) begin
            pow2    = (CNT_W+1)'(1) << (code - CODE_W'(1));
            pow2_m1 = pow2 - (CNT_W+1)'(1);
        end
        term_cnt = pow2_m1[CNT_W-1:0];
    end

endmodule

// File: rtl/div_counter.sv
// div_counter: counts system cycles and emits a one-cycle tick when the
// count reaches its terminal value. Assumes term_cnt changes only on a cycle
// where restart is high.
module div_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [CNT_W-1:0] term_cnt,
    output logic             tick
);

    logic [CNT_W-1:0] cnt_q;

    // Count up, wrapping at the terminal count; clear on restart or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == term_cnt) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Tick in the last cycle of each divided period.
    assign tick = run && (cnt_q == term_cnt);

    // R4
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= term_cnt));

endmodule

// File: rtl/scaler_channel.sv
// scaler_channel: one channel's stored code, sticky illegal-code flag and
// divider. Assumes wr_hit is already qualified with the channel index.
module scaler_channel
    import clk_scaler_pkg::*;
#(
    parameter int unsigned CODE_W   = 4,
    parameter int unsigned MAX_CODE = 9,
    parameter int unsigned CNT_W    = MAX_CODE - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [CODE_W-1:0] wr_code,
    output logic              tick,
    output logic              active,
    output logic              rsvd_seen
);

    logic [CODE_W-1:0] code_q;
    logic              rsvd_q;
    scale_mode_t       mode;
    logic [CNT_W-1:0]  term_cnt;

    // Hold the scale code; reset to off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= CODE_W'(CODE_OFF);
        end else if (wr_hit) begin
            code_q <= wr_code;
        end
    end

    // Remember any write of an illegal code until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsvd_q <= 1'b0;
        end else if (wr_hit && (wr_code > CODE_W'(MAX_CODE))) begin
            rsvd_q <= 1'b1;
        end
    end

    scale_decode #(
        .CODE_W   (CODE_W),
        .MAX_CODE (MAX_CODE),
        .CNT_W    (CNT_W)
    ) u_dec (
        .code     (code_q),
        .mode     (mode),
        .term_cnt (term_cnt)
    );

    div_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (wr_hit),
        .run      (mode.running),
        .term_cnt (term_cnt),
        .tick     (tick)
    );

    assign active    = mode.running;
    assign rsvd_seen = rsvd_q;

    // R5
    first_tick_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && (wr_code > CODE_W'(1)) && (wr_code <= CODE_W'(MAX_CODE)))
        |=> !tick);

    // R4
    no_double_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (term_cnt != '0) && !wr_hit) |=> !tick);

    // R6
    rsvd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd_q |=> rsvd_q);

    // R6
    rsvd_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode.illegal |-> (!tick && rsvd_q));

endmodule

// File: rtl/access_gate.sv
// access_gate: forwards peripheral requests for running channels and flags
// requests aimed at channels that are off. Purely combinational.
module access_gate #(
    parameter int unsigned NUM_CH = 4
) (
    input  logic [NUM_CH-1:0] req,
    input  logic [NUM_CH-1:0] running,
    output logic [NUM_CH-1:0] grant,
    output logic [NUM_CH-1:0] err
);

    // Split each request by whether its channel clock runs.
    always_comb begin
        grant = req & running;
        err   = req & ~running;
    end

endmodule

// File: rtl/clk_scaler_bank.sv
// clk_scaler_bank: top level. Decodes the shared write port to one channel,
// instantiates one scaler per channel and gates access requests.
// Assumes NUM_CH >= 2 and a single system clock.
module clk_scaler_bank #(
    parameter int unsigned NUM_CH   = 4,
    parameter int unsigned CODE_W   = 4,
    parameter int unsigned MAX_CODE = 9,
    localparam int unsigned CH_W    = $clog2(NUM_CH),
    localparam int unsigned CNT_W   = MAX_CODE - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [CODE_W-1:0] wr_code,
    input  logic [NUM_CH-1:0] acc_req,
    output logic [NUM_CH-1:0] clk_en,
    output logic [NUM_CH-1:0] ch_active,
    output logic [NUM_CH-1:0] code_rsvd,
    output logic [NUM_CH-1:0] acc_grant,
    output logic [NUM_CH-1:0] acc_err
);

    logic [NUM_CH-1:0] wr_hit;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        // Route the write only to the addressed channel.
        assign wr_hit[i] = wr_en && (wr_ch == CH_W'(i));

        scaler_channel #(
            .CODE_W   (CODE_W),
            .MAX_CODE (MAX_CODE),
            .CNT_W    (CNT_W)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_hit    (wr_hit[i]),
            .wr_code   (wr_code),
            .tick      (clk_en[i]),
            .active    (ch_active[i]),
            .rsvd_seen (code_rsvd[i])
        );

        // R7
        other_ch_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_hit[i]) |=> ($stable(ch_active[i]) && $stable(code_rsvd[i])));

        // R2
        idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_active[i]) |-> !clk_en[i]);
    end

    access_gate #(
        .NUM_CH (NUM_CH)
    ) u_gate (
        .req     (acc_req),
        .running (ch_active),
        .grant   (acc_grant),
        .err     (acc_err)
    );

    // R8
    gate_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_grant | acc_err) == acc_req) && ((acc_grant & acc_err) == '0));

endmodule

// File: tb/sim_clk_scaler_bank.sv
module sim_clk_scaler_bank;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_ch = '0;
    logic [3:0] wr_code = '0;
    logic [3:0] acc_req = '0;
    logic [3:0] clk_en, ch_active, code_rsvd, acc_grant, acc_err;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    clk_scaler_bank u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch),
        .wr_code(wr_code), .acc_req(acc_req), .clk_en(clk_en),
        .ch_active(ch_active), .code_rsvd(code_rsvd),
        .acc_grant(acc_grant), .acc_err(acc_err)
    );

    typedef struct packed {
        logic [3:0]      en;
        logic [3:0]      act;
        logic [3:0]      rsv;
        logic [3:0]      gnt;
        logic [3:0]      err;
        logic [3:0][3:0] tag;
    } exp_t;

    exp_t q[$];

    // Reference model state per channel.
    int         mcode [4];
    int         mk    [4];
    logic [3:0] mrsvd;

    function automatic bit legal(int c);
        return (c >= 1) && (c <= 9);
    endfunction

    task automatic check(input string req, input int ch, input logic got,
                         input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s ch%0d: got %b expected %b", req, ch, got, exp);
        end
    endtask

    // Driver: apply one cycle of inputs and push the expected outputs.
    task automatic step(input bit wr, input int ch, input int code,
                        input logic [3:0] req);
        exp_t e;
        @(posedge clk);
        #2;
        wr_en   = wr;
        wr_ch   = 2'(ch);
        wr_code = 4'(code);
        acc_req = req;
        for (int i = 0; i < 4; i++) begin
            int d;
            d = legal(mcode[i]) ? (1 << (mcode[i] - 1)) : 1;
            e.act[i] = legal(mcode[i]);                        // R9
            e.en[i]  = legal(mcode[i]) && (mk[i] % d == 0);
            e.rsv[i] = mrsvd[i];
            e.gnt[i] = req[i] && e.act[i];                     // R8
            e.err[i] = req[i] && !e.act[i];
            if (mcode[i] == 0)       e.tag[i] = 4'd2;          // R2
            else if (mcode[i] > 9)   e.tag[i] = 4'd6;          // R6
            else if (mcode[i] == 1)  e.tag[i] = 4'd3;          // R3
            else if (mk[i] <= d)     e.tag[i] = 4'd5;          // R5
            else                     e.tag[i] = 4'd4;          // R4
        end
        q.push_back(e);
        if (wr) begin
            mcode[ch] = code;
            mk[ch]    = 0;          // R7: only the addressed channel restarts
            if (code > 9) mrsvd[ch] = 1'b1;
        end
        for (int i = 0; i < 4; i++) mk[i]++;
    endtask

    task automatic idle(input int n, input logic [3:0] req);
        for (int j = 0; j < n; j++) step(1'b0, 0, 0, req);
    endtask

    // Monitor: pop expected items and compare late in each cycle.
    initial begin
        forever begin
            @(posedge clk);
            #15;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                for (int i = 0; i < 4; i++) begin
                    check($sformatf("R%0d", e.tag[i]), i, clk_en[i], e.en[i]);
                    check("R9", i, ch_active[i], e.act[i]);
                    check("R6", i, code_rsvd[i], e.rsv[i]);
                    check("R8", i, acc_grant[i], e.gnt[i]);
                    check("R8", i, acc_err[i], e.err[i]);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin mcode[i] = 0; mk[i] = 1; end
        mrsvd = '0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #11;
        // R1: reset state at the ports
        for (int i = 0; i < 4; i++) begin
            check("R1", i, clk_en[i], 1'b0);
            check("R1", i, ch_active[i], 1'b0);
            check("R1", i, code_rsvd[i], 1'b0);
        end
        idle(4, 4'b1111);                // R2, R8 while all channels are off
        step(1'b1, 0, 1, 4'b0000);       // R3: full rate
        step(1'b1, 1, 2, 4'b0000);       // divide by 2
        step(1'b1, 2, 4, 4'b0000);       // divide by 8
        step(1'b1, 3, 9, 4'b0000);       // divide by 256
        idle(40, 4'b0000);
        idle(6, 4'b1010);
        step(1'b1, 1, 3, 4'b0000);       // R5: mid-period rewrite, R7 on others
        idle(30, 4'b0101);
        step(1'b1, 2, 4, 4'b0000);       // R5: same code rewrite restarts
        idle(560, 4'b0000);              // covers the /256 period twice
        step(1'b1, 0, 10, 4'b0000);      // R6: lowest reserved code
        step(1'b1, 3, 15, 4'b0000);      // R6: highest reserved code
        idle(20, 4'b1111);
        step(1'b1, 0, 0, 4'b0001);       // back to off; flag stays
        step(1'b1, 1, 5, 4'b0000);       // divide by 16
        idle(50, 4'b0011);
        step(1'b1, 3, 6, 4'b0000);       // divide by 32 after reserved
        step(1'b1, 0, 7, 4'b0000);       // divide by 64
        step(1'b1, 2, 8, 4'b0000);       // divide by 128
        idle(300, 4'b0000);
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule